// File: doc/BRIEF.md
# Single-Step Trap and Interrupt Sequencer

This block sits beside the execution unit of a simple in-order processor and decides, at every instruction boundary, what happens next: the single-step trap (vector type 1), a maskable external interrupt, or the next instruction. The execution unit reports each retired instruction with a one-cycle `retire` pulse, a class code, and the trace and interrupt-enable flag values that hold after that instruction. It also supplies the external request line and that request's vector type.

When an entry is due, the block sends one `entry_req` pulse with `entry_vec`. For an external entry it also pulses `irq_ack`. It then holds `busy` high until the execution unit reports `entry_done`, which means flags, segment and return address have been pushed and both flags cleared. Only after that can a chained entry follow, or the next instruction start.

The block models three kinds of timing:
- Trace-flag changes take effect with a delay.
- A segment load opens a one-boundary shadow, and the interrupt-enable flag is recognised one instruction late.
- A single-step trap follows an external entry, and another follows the return from an external handler.

A small frame stack records, for each nested entry, whether it was external. This lets a return tell an external handler apart from a software-interrupt or trap handler.

Top module: `step_trap_seq`

## Requirements
- R1: After reset, `entry_req`, `irq_ack` and `busy` are low.
- R2: Instruction j is followed by a trap (vector 1) when the trace flag was set both after instruction j-1 and after instruction j-2. Entry sequences and handler code count as flag value 0. So after the instruction that sets the flag, and after the one following it, no trap is raised, and a trap is raised after the next one.
- R3: The instruction that clears the trace flag is still followed by one trap. The instruction after it is not.
- R4: Any entry resets the trace and interrupt-enable history. The first handler instruction raises no trap and takes no external request, even if it reports both flags set and `irq_req` is high.
- R5: When an external entry is taken while `tf_new` is 1, a trap entry (vector 1) is requested right after its `entry_done`, with `irq_ack` low.
- R6: A return (class 5) that pops an external frame and reports `tf_new`=1 is followed by a trap at that same boundary.
- R7: A return that pops a software-interrupt frame (pushed by class 4) raises no trap at that boundary, even with tracing restored. The next instruction is traced again.
- R8: At any return boundary, a pending external request is taken if `if_new` is 1. This holds right after a software-interrupt return, and after a trap-handler return, where no trap is raised.
- R9: A segment load (class 3) blocks both the trap and the external entry at its own boundary. The following boundary is judged normally.
- R10: When the trap and the external request are both eligible, the trap is requested first. The external request stays pending through the trap handler and is taken at that handler's return.
- R11: Away from returns, an external request is taken at boundary j only when the interrupt-enable flag was set both after instruction j-1 and after j. An instruction that sets the flag (class 1 or 2) therefore takes no request at its own boundary, and does at the next.
- R12: `entry_req` is a one-cycle pulse. `irq_ack` is high only together with an external `entry_req`. `busy` stays high from the pulse until `entry_done` is received. Classes are 0 other, 1 flag load, 2 enable interrupt, 3 segment load, 4 software interrupt, 5 interrupt return.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| retire | input | 1 | One-cycle pulse: an instruction retired |
| retire_cls | input | 3 | Class of the retired instruction |
| tf_new | input | 1 | Trace flag after the retired instruction |
| if_new | input | 1 | Interrupt-enable flag after the retired instruction |
| irq_req | input | 1 | External interrupt request level |
| irq_vec | input | VEC_W | Vector type of the external request |
| entry_done | input | 1 | Entry sequence finished |
| entry_req | output | 1 | One-cycle request to enter a handler |
| entry_vec | output | VEC_W | Vector type of the requested entry |
| irq_ack | output | 1 | Acknowledge of the external request |
| busy | output | 1 | Boundary decision or entry in progress; the next instruction must wait |

## Verification
A decision takes one register stage. `entry_req`, `entry_vec` and `irq_ack` are due in the cycle right after the clock edge that samples `retire`. The bench drives on falling edges and reads these outputs at the very next falling edge. A chained trap is due one cycle after the edge that samples `entry_done`, so it is read at the falling edge after `entry_done` is released. The fall of `busy` is read at that same point. Each scenario feeds an exact sequence of retired classes and flag values, and checks every boundary in it, including those where nothing must happen.

// File: rtl/step_trap_seq.sv
module step_trap_seq #(
  parameter int VEC_W = 8,
  parameter int DEPTH = 8,
  parameter logic [VEC_W-1:0] TRAP_VEC = 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             retire,
  input  logic [2:0]       retire_cls,
  input  logic             tf_new,
  input  logic             if_new,
  input  logic             irq_req,
  input  logic [VEC_W-1:0] irq_vec,
  input  logic             entry_done,
  output logic             entry_req,
  output logic [VEC_W-1:0] entry_vec,
  output logic             irq_ack,
  output logic             busy
);
  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam logic [PW:0] FULL = DEPTH[PW:0];
  localparam logic [2:0] C_SEG = 3'd3, C_SWI = 3'd4, C_RET = 3'd5;

  typedef enum logic [1:0] {S_IDLE, S_ISSUE, S_WAIT} st_t;

  st_t st;
  logic h1, h2, ifh;
  logic ext_r, chain_r;
  logic [VEC_W-1:0] vec_r;
  logic [DEPTH-1:0] frm;
  logic [PW:0] sp, spm1;

  logic accept, is_ret, shadow, top_ext, trap_hit, ext_hit;

  assign spm1     = sp - 1'b1;
  assign top_ext  = (sp != '0) && frm[spm1[PW-1:0]];
  assign accept   = retire && (st == S_IDLE);
  assign is_ret   = retire_cls == C_RET;
  assign shadow   = retire_cls == C_SEG;
  assign trap_hit = !shadow && (is_ret ? (top_ext && tf_new) : (h1 && h2));
  assign ext_hit  = !shadow && irq_req && if_new && (is_ret || ifh);

  assign entry_req = st == S_ISSUE;
  assign entry_vec = vec_r;
  assign irq_ack   = (st == S_ISSUE) && ext_r;
  assign busy      = st != S_IDLE;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st <= S_IDLE;
      h1 <= 1'b0;
      h2 <= 1'b0;
      ifh <= 1'b0;
      ext_r <= 1'b0;
      chain_r <= 1'b0;
      vec_r <= '0;
      frm <= '0;
      sp <= '0;
    end else begin
      case (st)
        S_IDLE: if (accept) begin
          ifh <= if_new;
          if (retire_cls == C_SWI) begin
            h1 <= 1'b0;
            h2 <= 1'b0;
            if (sp < FULL) begin
              frm[sp[PW-1:0]] <= 1'b0;
              sp <= sp + 1'b1;
            end
          end else if (is_ret) begin
            h1 <= tf_new;
            h2 <= tf_new;
            if (sp != '0) sp <= spm1;
          end else begin
            h2 <= h1;
            h1 <= tf_new;
          end
          if (trap_hit) begin
            st <= S_ISSUE;
            vec_r <= TRAP_VEC;
            ext_r <= 1'b0;
            chain_r <= 1'b0;
          end else if (ext_hit) begin
            st <= S_ISSUE;
            vec_r <= irq_vec;
            ext_r <= 1'b1;
            chain_r <= tf_new;
          end
        end
        S_ISSUE: begin
          st <= S_WAIT;
          h1 <= 1'b0;
          h2 <= 1'b0;
          ifh <= 1'b0;
          if (sp < FULL) begin
            frm[sp[PW-1:0]] <= ext_r;
            sp <= sp + 1'b1;
          end
        end
        S_WAIT: if (entry_done) begin
          if (chain_r) begin
            st <= S_ISSUE;
            vec_r <= TRAP_VEC;
            ext_r <= 1'b0;
            chain_r <= 1'b0;
          end else begin
            st <= S_IDLE;
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/step_trap_seq_chk.sv
module step_trap_seq_chk #(
  parameter int VEC_W = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             retire,
  input logic [2:0]       retire_cls,
  input logic             entry_done,
  input logic             entry_req,
  input logic [VEC_W-1:0] entry_vec,
  input logic             irq_ack,
  input logic             busy
);
  AST_RESET_QUIET: assert property (@(posedge clk) !rst_n |=> (!busy && !entry_req && !irq_ack)); // R1
  AST_REQ_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n) entry_req |=> !entry_req); // R12
  AST_ACK_NEEDS_REQ: assert property (@(posedge clk) disable iff (!rst_n) irq_ack |-> entry_req); // R12
  AST_BUSY_STARTS_WITH_REQ: assert property (@(posedge clk) disable iff (!rst_n) $rose(busy) |-> entry_req); // R12
  AST_BUSY_HOLDS: assert property (@(posedge clk) disable iff (!rst_n) (busy && !entry_req && !entry_done) |=> busy); // R12
  AST_SEG_SHADOW: assert property (@(posedge clk) disable iff (!rst_n) (retire && !busy && retire_cls == 3'd3) |=> !entry_req); // R9
endmodule

bind step_trap_seq step_trap_seq_chk #(.VEC_W(VEC_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .retire(retire), .retire_cls(retire_cls),
  .entry_done(entry_done), .entry_req(entry_req), .entry_vec(entry_vec),
  .irq_ack(irq_ack), .busy(busy)
);

// File: tb/tb_step_trap_seq.sv
module tb_step_trap_seq;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic retire = 1'b0;
  logic [2:0] retire_cls = 3'd0;
  logic tf_new = 1'b0, if_new = 1'b0, irq_req = 1'b0, entry_done = 1'b0;
  logic [7:0] irq_vec = 8'h20;
  logic entry_req, irq_ack, busy;
  logic [7:0] entry_vec;

  int checks = 0;
  int errors = 0;
  logic g_req, g_ack;
  logic [7:0] g_vec;

  localparam logic [2:0] OTH = 3'd0, FLG = 3'd1, STI = 3'd2, SEG = 3'd3, SWI = 3'd4, RET = 3'd5;

  step_trap_seq dut (
    .clk(clk), .rst_n(rst_n), .retire(retire), .retire_cls(retire_cls),
    .tf_new(tf_new), .if_new(if_new), .irq_req(irq_req), .irq_vec(irq_vec),
    .entry_done(entry_done), .entry_req(entry_req), .entry_vec(entry_vec),
    .irq_ack(irq_ack), .busy(busy)
  );

  always #5 clk = ~clk;

  task automatic chk(input string req, input logic [7:0] got, input logic [7:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %0h expected %0h", req, got, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; retire = 1'b0; entry_done = 1'b0; irq_req = 1'b0;
    @(negedge clk);
    @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic ret_instr(input logic [2:0] c, input logic tf, input logic ifl);
    retire = 1'b1; retire_cls = c; tf_new = tf; if_new = ifl;
    @(negedge clk);
    retire = 1'b0;
    g_req = entry_req; g_vec = entry_vec; g_ack = irq_ack;
  endtask

  task automatic expect_none(input string req, input logic [2:0] c, input logic tf, input logic ifl);
    ret_instr(c, tf, ifl);
    chk(req, {7'd0, g_req}, 8'd0);
  endtask

  task automatic expect_entry(input string req, input logic [2:0] c, input logic tf, input logic ifl,
                              input logic [7:0] vec, input logic ack);
    ret_instr(c, tf, ifl);
    chk(req, {7'd0, g_req}, 8'd1);
    chk(req, g_vec, vec);
    chk(req, {7'd0, g_ack}, {7'd0, ack});
  endtask

  task automatic finish_entry();
    @(negedge clk);
    entry_done = 1'b1;
    @(negedge clk);
    entry_done = 1'b0;
    g_req = entry_req; g_vec = entry_vec; g_ack = irq_ack;
  endtask

  task automatic trace_on(input logic ifl);
    expect_none("R2", FLG, 1'b1, ifl);
    expect_none("R2", OTH, 1'b1, ifl);
    expect_entry("R2", OTH, 1'b1, ifl, 8'h01, 1'b0);
    finish_entry();
    chk("R2", {7'd0, g_req}, 8'd0);
    expect_none("R10", RET, 1'b1, ifl);
  endtask

  task automatic t_reset();
    do_reset();
    chk("R1", {5'd0, entry_req, irq_ack, busy}, 8'd0);
  endtask

  task automatic t_set_trace();
    do_reset();
    expect_none("R2", OTH, 1'b0, 1'b0);
    trace_on(1'b0);
    expect_entry("R2", OTH, 1'b1, 1'b0, 8'h01, 1'b0);
    finish_entry();
    expect_none("R2", RET, 1'b1, 1'b0);
  endtask

  task automatic t_clear_trace();
    do_reset();
    trace_on(1'b0);
    expect_entry("R3", FLG, 1'b0, 1'b0, 8'h01, 1'b0);
    finish_entry();
    expect_none("R3", RET, 1'b0, 1'b0);
    expect_none("R3", OTH, 1'b0, 1'b0);
    expect_none("R3", OTH, 1'b0, 1'b0);
  endtask

  task automatic t_handler_clean();
    do_reset();
    expect_none("R4", FLG, 1'b1, 1'b1);
    expect_none("R4", OTH, 1'b1, 1'b1);
    expect_entry("R4", OTH, 1'b1, 1'b1, 8'h01, 1'b0);
    finish_entry();
    irq_req = 1'b1;
    expect_none("R4", OTH, 1'b1, 1'b1);
    irq_req = 1'b0;
  endtask

  task automatic t_ext_chain();
    do_reset();
    irq_vec = 8'h20;
    expect_none("R10", FLG, 1'b1, 1'b1);
    expect_none("R10", OTH, 1'b1, 1'b1);
    irq_req = 1'b1;
    expect_entry("R10", OTH, 1'b1, 1'b1, 8'h01, 1'b0);
    @(negedge clk);
    chk("R12", {6'd0, entry_req, busy}, 8'd1);
    entry_done = 1'b1;
    @(negedge clk);
    entry_done = 1'b0;
    chk("R12", {6'd0, entry_req, busy}, 8'd0);
    expect_none("R10", OTH, 1'b0, 1'b0);
    expect_entry("R10", RET, 1'b1, 1'b1, 8'h20, 1'b1);
    irq_req = 1'b0;
    finish_entry();
    chk("R5", {7'd0, g_req}, 8'd1);
    chk("R5", g_vec, 8'h01);
    chk("R5", {7'd0, g_ack}, 8'd0);
    finish_entry();
    chk("R5", {7'd0, g_req}, 8'd0);
    expect_none("R6", RET, 1'b0, 1'b0);
    expect_none("R6", OTH, 1'b0, 1'b0);
    expect_entry("R6", RET, 1'b1, 1'b1, 8'h01, 1'b0);
    finish_entry();
  endtask

  task automatic t_soft_return();
    do_reset();
    trace_on(1'b1);
    expect_entry("R7", SWI, 1'b0, 1'b0, 8'h01, 1'b0);
    finish_entry();
    expect_none("R7", RET, 1'b0, 1'b0);
    expect_none("R7", OTH, 1'b0, 1'b0);
    expect_none("R7", RET, 1'b1, 1'b1);
    expect_entry("R7", OTH, 1'b1, 1'b1, 8'h01, 1'b0);
    finish_entry();
  endtask

  task automatic t_soft_ext();
    do_reset();
    irq_vec = 8'h33;
    expect_none("R8", OTH, 1'b0, 1'b1);
    expect_none("R8", SWI, 1'b0, 1'b0);
    expect_none("R8", OTH, 1'b0, 1'b0);
    irq_req = 1'b1;
    expect_entry("R8", RET, 1'b0, 1'b1, 8'h33, 1'b1);
    irq_req = 1'b0;
    finish_entry();
    chk("R8", {7'd0, g_req}, 8'd0);
  endtask

  task automatic t_seg_shadow();
    do_reset();
    irq_vec = 8'h21;
    expect_none("R9", FLG, 1'b1, 1'b1);
    expect_none("R9", OTH, 1'b1, 1'b1);
    irq_req = 1'b1;
    expect_none("R9", SEG, 1'b1, 1'b1);
    expect_entry("R9", OTH, 1'b1, 1'b1, 8'h01, 1'b0);
    finish_entry();
    irq_req = 1'b0;
  endtask

  task automatic t_if_delay();
    do_reset();
    irq_vec = 8'h44;
    irq_req = 1'b1;
    expect_none("R11", STI, 1'b0, 1'b1);
    expect_entry("R11", OTH, 1'b0, 1'b1, 8'h44, 1'b1);
    irq_req = 1'b0;
    finish_entry();
    chk("R11", {7'd0, busy}, 8'd0);
    irq_req = 1'b1;
    expect_none("R11", OTH, 1'b0, 1'b0);
    expect_none("R11", FLG, 1'b0, 1'b1);
    expect_entry("R11", OTH, 1'b0, 1'b1, 8'h44, 1'b1);
    irq_req = 1'b0;
    finish_entry();
  endtask

  initial begin
    fork
      begin
        t_reset();
        t_set_trace();
        t_clear_trace();
        t_handler_clean();
        t_ext_chain();
        t_soft_return();
        t_soft_ext();
        t_seg_shadow();
        t_if_delay();
      end
      begin
        repeat (20000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: got timeout expected completion");
      end
    join_any
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule